// File: doc/BRIEF.md
# Two-Level TLB Maintenance Engine

This block holds the translation entries of a TLB and carries out the maintenance commands a processor issues against them. It has two parts. The set-associative part has 8 ways by `SETS` sets, and all of its entries share one page size taken from an input. The fully-associative part has `FA_N` entries, and each of those stores its own page size. Every entry holds a virtual page-pair number, a 10-bit address-space identifier, a page size, an exists flag and two page descriptors, one for the even page and one for the odd page. The global flag of an entry is bit 6 of its even descriptor.

A command arrives as an opcode plus a set of register-style operands. The available commands are search, read, indexed write, fill, clear, flush and five invalidate variants. A command that touches more than one entry walks those entries one per clock. Every command ends with a one-cycle `done` pulse, and its results appear on the result ports in that same cycle. A free-running LFSR picks the victim way or slot for a fill. When a write or fill overwrites an entry that a downstream translation cache may still hold, the block raises a shootdown pulse for that entry.

Top module: `tlb_maint`

## Requirements
- R1: A command is accepted when `cmd_valid` is high and `busy` is low. `busy` then stays high until a one-cycle `done` pulse. The result ports change only in a `done` cycle. Opcodes: 0 search, 1 read, 2 write, 3 fill, 4 clear, 5 flush, 6 invalidate all, 7 invalidate by global value, 8 invalidate by ASID, 9 invalidate page by ASID, 10 invalidate page by ASID or global.
- R2: An index below 8·SETS selects way index/SETS and set index%SETS of the set-associative part. An index from 8·SETS to 8·SETS+FA_N−1 selects a fully-associative entry.
- R3: A write (opcode 2) with `cmd_ne`=0 stores VPPN=`cmd_va[47:13]`, ASID=`cur_asid`, page size `cmd_ps` and both descriptors, and sets the exists flag. With `cmd_ne`=1 it only clears the exists flag.
- R4: A read (opcode 1) of an existing entry gives `res_ne`=0 and returns the page size (the shared size for the set-associative part, the stored size for the fully-associative part), `res_ehi`=VPPN<<13, both descriptors and the ASID. A read of an entry that does not exist gives `res_ne`=1, and every other read result is zero.
- R5: A search (opcode 0) hits an entry that exists, is global or has ASID equal to `cur_asid`, and matches the page. On a hit it returns that index with `res_ne`=0. On a miss it sets `res_ne`=1 and leaves `res_idx` unchanged.
- R6: A page matches when (VA >> (ps+1)) equals ({VPPN,13'b0} >> (ps+1)), where ps is the page size that applies to the entry.
- R7: A fill (opcode 3) with `cmd_ps` equal to `shared_ps` writes way LFSR-chosen in set (VA>>(ps+1)) mod SETS. Any other page size writes a random fully-associative entry.
- R8: A clear (opcode 4) with a set-associative index clears the exists flag in all 8 ways of set index%SETS. With a fully-associative index it does the same over the whole fully-associative part. In both cases only non-global entries whose ASID equals `cur_asid` are cleared.
- R9: A flush (opcode 5) covers the same entries as a clear but ignores the global flag and the ASID.
- R10: Invalidate all (opcode 6) clears every entry. Opcode 7 clears every entry whose global flag equals `inv_g`.
- R11: Opcode 8 clears every non-global entry whose ASID equals `inv_asid`.
- R12: Opcode 9 clears non-global entries with ASID `inv_asid` whose page matches `cmd_va`. Opcode 10 clears entries that are global or have ASID `inv_asid` and whose page matches `cmd_va`.
- R13: A write or fill pulses `sd_valid` with `sd_idx` in its `done` cycle when the entry it overwrites existed and was global or had ASID equal to `cur_asid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 4 | Opcode |
| cmd_idx | input | IDX_W | Entry index operand |
| cmd_ne | input | 1 | Not-exist flag for write |
| cmd_va | input | 48 | Virtual address operand |
| cmd_ps | input | 6 | Requested page size |
| cmd_lo0 | input | 16 | Even page descriptor |
| cmd_lo1 | input | 16 | Odd page descriptor |
| cur_asid | input | 10 | Current address-space ID |
| shared_ps | input | 6 | Page size of set-associative part |
| inv_asid | input | 10 | ASID operand of invalidates |
| inv_g | input | 1 | Global value operand of invalidate |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command complete pulse |
| res_ne | output | 1 | Not-exist / miss result |
| res_idx | output | IDX_W | Search hit index |
| res_ps | output | 6 | Read page size |
| res_ehi | output | 48 | Read page address |
| res_lo0 | output | 16 | Read even descriptor |
| res_lo1 | output | 16 | Read odd descriptor |
| res_asid | output | 10 | Read ASID |
| sd_valid | output | 1 | Shootdown pulse |
| sd_idx | output | IDX_W | Shootdown entry index |

## Verification
Internal state shows at the ports only through later commands. A corrupted exists flag or a bad stored field stays hidden until a read or search of that entry. A maintenance walk that clears the wrong entries becomes visible only when the bench reads back both the victims and the survivors. For this reason every write, clear and invalidate is followed at once by reads or searches of the entries it should and should not have touched. For fills the exact victim is random, so a search locates the entry and its set and part are checked.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    parameter int unsigned VA_W   = 48;
    parameter int unsigned PG_LSB = 13;
    parameter int unsigned VPPN_W = VA_W - PG_LSB;
    parameter int unsigned ASID_W = 10;
    parameter int unsigned PS_W   = 6;
    parameter int unsigned LO_W   = 16;
    parameter int unsigned G_BIT  = 6;
    parameter int unsigned WAYS   = 8;

    typedef enum logic [3:0] {
        OP_SRCH = 4'd0, OP_RD = 4'd1, OP_WR = 4'd2, OP_FILL = 4'd3,
        OP_CLR = 4'd4, OP_FLUSH = 4'd5, OP_INV_ALL = 4'd6, OP_INV_G = 4'd7,
        OP_INV_ASID = 4'd8, OP_INV_PG = 4'd9, OP_INV_PG_G = 4'd10
    } op_e;

    typedef struct packed {
        logic [VPPN_W-1:0] vppn;
        logic [ASID_W-1:0] asid;
        logic [PS_W-1:0]   ps;
        logic [LO_W-1:0]   lo0;
        logic [LO_W-1:0]   lo1;
    } ent_t;
endpackage

// File: rtl/tlb_lfsr.sv
module tlb_lfsr #(
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [15:0] rnd
);
    logic [15:0] lfsr_d, lfsr_q;

    always_comb begin
        lfsr_d = {1'b0, lfsr_q[15:1]};
        if (lfsr_q[0]) lfsr_d = lfsr_d ^ 16'hB400;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr_q <= SEED;
        else        lfsr_q <= lfsr_d;
    end

    assign rnd = lfsr_q;

    // R7: victim source never locks up at zero
    a_r7_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != 16'h0);
endmodule

// File: rtl/tlb_pmatch.sv
module tlb_pmatch
    import tlb_pkg::*;
(
    input  logic [VA_W-1:0]   va,
    input  logic [VPPN_W-1:0] vppn,
    input  logic [PS_W-1:0]   ps,
    output logic              hit
);
    logic [VA_W-1:0] diff;
    logic [PS_W:0]   sh;

    always_comb begin
        diff = va ^ {vppn, {PG_LSB{1'b0}}};
        sh   = (PS_W+1)'(ps) + (PS_W+1)'(1);
        hit  = (diff >> sh) == '0;
    end
endmodule

// File: rtl/tlb_store.sv
module tlb_store
    import tlb_pkg::*;
#(
    parameter int unsigned N  = 2056,
    parameter int unsigned AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] raddr,
    output logic          rd_e,
    output ent_t          rd_ent,
    input  logic          we_full,
    input  logic          we_clr,
    input  logic [AW-1:0] waddr,
    input  ent_t          wdata
);
    logic [N-1:0] e_q;
    ent_t         mem_q [N];
    logic         r_ok, w_ok;

    assign r_ok   = 32'(raddr) < N;
    assign w_ok   = 32'(waddr) < N;
    assign rd_e   = r_ok ? e_q[raddr] : 1'b0;
    assign rd_ent = r_ok ? mem_q[raddr] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else if (w_ok && we_full) e_q[waddr] <= 1'b1;
        else if (w_ok && we_clr)  e_q[waddr] <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (w_ok && we_full) mem_q[waddr] <= wdata;
    end

    // R3: a step either loads an entry or clears its flag, never both
    a_r3_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_full && we_clr));
endmodule

// File: rtl/tlb_maint.sv
module tlb_maint
    import tlb_pkg::*;
#(
    parameter int unsigned SETS = 256,
    parameter int unsigned FA_N = 8,
    parameter logic [15:0] SEED = 16'hACE1,
    localparam int unsigned SA_N  = WAYS * SETS,
    localparam int unsigned N     = SA_N + FA_N,
    localparam int unsigned IDX_W = $clog2(N),
    localparam int unsigned SET_W = $clog2(SETS),
    localparam int unsigned FA_W  = $clog2(FA_N),
    localparam int unsigned WAY_W = $clog2(WAYS),
    localparam int unsigned CNT_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_op,
    input  logic [IDX_W-1:0]  cmd_idx,
    input  logic              cmd_ne,
    input  logic [VA_W-1:0]   cmd_va,
    input  logic [PS_W-1:0]   cmd_ps,
    input  logic [LO_W-1:0]   cmd_lo0,
    input  logic [LO_W-1:0]   cmd_lo1,
    input  logic [ASID_W-1:0] cur_asid,
    input  logic [PS_W-1:0]   shared_ps,
    input  logic [ASID_W-1:0] inv_asid,
    input  logic              inv_g,
    output logic              busy,
    output logic              done,
    output logic              res_ne,
    output logic [IDX_W-1:0]  res_idx,
    output logic [PS_W-1:0]   res_ps,
    output logic [VA_W-1:0]   res_ehi,
    output logic [LO_W-1:0]   res_lo0,
    output logic [LO_W-1:0]   res_lo1,
    output logic [ASID_W-1:0] res_asid,
    output logic              sd_valid,
    output logic [IDX_W-1:0]  sd_idx
);
    typedef struct packed {
        logic              busy, done, ne, inv_g, found;
        op_e               op;
        logic [IDX_W-1:0]  idx, fidx;
        logic [VA_W-1:0]   va;
        logic [PS_W-1:0]   ps;
        logic [LO_W-1:0]   lo0, lo1;
        logic [ASID_W-1:0] asid, inv_asid;
        logic [CNT_W-1:0]  cnt, last;
        logic              res_ne;
        logic [IDX_W-1:0]  res_idx;
        logic [PS_W-1:0]   res_ps;
        logic [VA_W-1:0]   res_ehi;
        logic [LO_W-1:0]   res_lo0, res_lo1;
        logic [ASID_W-1:0] res_asid;
        logic              sd_valid;
        logic [IDX_W-1:0]  sd_idx;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [15:0]      rnd;
    logic [SET_W-1:0] va_set;
    logic [31:0]      a32;
    logic [IDX_W-1:0] addr;
    logic             in_rng, rd_e, g, cur_ok, inv_ok, pm, kill, hit;
    logic             we_full, we_clr;
    logic [PS_W-1:0]  ps_eff;
    ent_t             rd_ent, wdata;

    tlb_lfsr #(.SEED(SEED)) u_lfsr (.clk(clk), .rst_n(rst_n), .rnd(rnd));

    tlb_store #(.N(N), .AW(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n), .raddr(addr), .rd_e(rd_e), .rd_ent(rd_ent),
        .we_full(we_full), .we_clr(we_clr), .waddr(addr), .wdata(wdata));

    tlb_pmatch u_pm (.va(ctl_q.va), .vppn(rd_ent.vppn), .ps(ps_eff), .hit(pm));

    // Entry address of the current walk step (R2, R7, R8)
    always_comb begin
        va_set = SET_W'(ctl_q.va >> ((PS_W+1)'(shared_ps) + (PS_W+1)'(1)));
        unique case (ctl_q.op)
            OP_SRCH: a32 = (32'(ctl_q.cnt) < WAYS)
                         ? 32'(ctl_q.cnt) * SETS + 32'(va_set)
                         : SA_N + 32'(ctl_q.cnt) - WAYS;
            OP_CLR, OP_FLUSH:
                if (32'(ctl_q.idx) < SA_N)
                    a32 = 32'(ctl_q.cnt) * SETS + 32'(ctl_q.idx) % SETS;
                else if (32'(ctl_q.idx) < N)
                    a32 = SA_N + 32'(ctl_q.cnt);
                else
                    a32 = N;
            OP_RD, OP_WR: a32 = 32'(ctl_q.idx);
            OP_FILL: a32 = (ctl_q.ps == shared_ps)
                         ? 32'(rnd[WAY_W-1:0]) * SETS + 32'(va_set)
                         : SA_N + 32'(rnd[FA_W-1:0]);
            default: a32 = 32'(ctl_q.cnt);
        endcase
        addr   = IDX_W'(a32);
        in_rng = a32 < N;
    end

    // Per-entry qualification
    always_comb begin
        ps_eff = (a32 >= SA_N) ? rd_ent.ps : shared_ps;
        g      = rd_ent.lo0[G_BIT];
        cur_ok = rd_ent.asid == ctl_q.asid;
        inv_ok = rd_ent.asid == ctl_q.inv_asid;
        hit    = rd_e && (g || cur_ok) && pm;
        unique case (ctl_q.op)
            OP_WR:       kill = ctl_q.ne;
            OP_CLR:      kill = !g && cur_ok;
            OP_FLUSH,
            OP_INV_ALL:  kill = 1'b1;
            OP_INV_G:    kill = g == ctl_q.inv_g;
            OP_INV_ASID: kill = !g && inv_ok;
            OP_INV_PG:   kill = !g && inv_ok && pm;
            OP_INV_PG_G: kill = (g || inv_ok) && pm;
            default:     kill = 1'b0;
        endcase
        we_clr  = ctl_q.busy && in_rng && kill;
        we_full = ctl_q.busy && in_rng &&
                  ((ctl_q.op == OP_WR && !ctl_q.ne) || ctl_q.op == OP_FILL);
        wdata   = '{vppn: ctl_q.va[VA_W-1:PG_LSB], asid: ctl_q.asid,
                    ps: ctl_q.ps, lo0: ctl_q.lo0, lo1: ctl_q.lo1};
    end

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.done     = 1'b0;
        ctl_d.sd_valid = 1'b0;
        if (!ctl_q.busy) begin
            if (cmd_valid) begin
                ctl_d.busy     = 1'b1;
                ctl_d.op       = op_e'(cmd_op);
                ctl_d.idx      = cmd_idx;
                ctl_d.ne       = cmd_ne;
                ctl_d.va       = cmd_va;
                ctl_d.ps       = cmd_ps;
                ctl_d.lo0      = cmd_lo0;
                ctl_d.lo1      = cmd_lo1;
                ctl_d.asid     = cur_asid;
                ctl_d.inv_asid = inv_asid;
                ctl_d.inv_g    = inv_g;
                ctl_d.cnt      = '0;
                ctl_d.found    = 1'b0;
                unique case (op_e'(cmd_op))
                    OP_SRCH: ctl_d.last = CNT_W'(WAYS + FA_N - 1);
                    OP_CLR, OP_FLUSH:
                        ctl_d.last = (32'(cmd_idx) < SA_N) ? CNT_W'(WAYS - 1)
                                   : (32'(cmd_idx) < N) ? CNT_W'(FA_N - 1) : '0;
                    OP_INV_ALL, OP_INV_G, OP_INV_ASID, OP_INV_PG, OP_INV_PG_G:
                        ctl_d.last = CNT_W'(N - 1);
                    default: ctl_d.last = '0;
                endcase
            end
        end else begin
            if (ctl_q.op == OP_SRCH && in_rng && hit && !ctl_q.found) begin
                ctl_d.found = 1'b1;
                ctl_d.fidx  = addr;
            end
            if (ctl_q.cnt == ctl_q.last) begin
                ctl_d.busy = 1'b0;
                ctl_d.done = 1'b1;
                unique case (ctl_q.op)
                    OP_SRCH: begin
                        ctl_d.res_ne = !ctl_d.found;
                        if (ctl_d.found) ctl_d.res_idx = ctl_d.fidx;
                    end
                    OP_RD: begin
                        ctl_d.res_ne   = !(rd_e && in_rng);
                        ctl_d.res_ps   = ctl_d.res_ne ? '0 : ps_eff;
                        ctl_d.res_ehi  = ctl_d.res_ne ? '0 : {rd_ent.vppn, {PG_LSB{1'b0}}};
                        ctl_d.res_lo0  = ctl_d.res_ne ? '0 : rd_ent.lo0;
                        ctl_d.res_lo1  = ctl_d.res_ne ? '0 : rd_ent.lo1;
                        ctl_d.res_asid = ctl_d.res_ne ? '0 : rd_ent.asid;
                    end
                    OP_WR, OP_FILL: begin
                        ctl_d.sd_valid = in_rng && rd_e && (g || cur_ok);
                        ctl_d.sd_idx   = addr;
                    end
                    default: ;
                endcase
            end else begin
                ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign busy     = ctl_q.busy;
    assign done     = ctl_q.done;
    assign res_ne   = ctl_q.res_ne;
    assign res_idx  = ctl_q.res_idx;
    assign res_ps   = ctl_q.res_ps;
    assign res_ehi  = ctl_q.res_ehi;
    assign res_lo0  = ctl_q.res_lo0;
    assign res_lo1  = ctl_q.res_lo1;
    assign res_asid = ctl_q.res_asid;
    assign sd_valid = ctl_q.sd_valid;
    assign sd_idx   = ctl_q.sd_idx;

    a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r1_accept: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !busy |=> busy);
    a_r1_results_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(res_idx) || !$stable(res_ne) |-> done);
    a_r13_shootdown_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        sd_valid |-> done);
    a_r4_absent_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        done && res_ne && ctl_q.op == OP_RD |->
            res_lo0 == '0 && res_lo1 == '0 && res_ehi == '0 && res_ps == '0 && res_asid == '0);
    a_r5_miss_keeps_idx: assert property (@(posedge clk) disable iff (!rst_n)
        done && res_ne && ctl_q.op == OP_SRCH |-> $stable(res_idx));
endmodule

// File: tb/tlb_maint_tb_top.sv
module tlb_maint_tb_top;
    localparam int IDX_W = 12;

    logic clk = 1'b0, rst_n = 1'b0;
    always #2 clk = ~clk;

    logic              cmd_valid = 1'b0, cmd_ne = 1'b0, inv_g = 1'b0;
    logic [3:0]        cmd_op = '0;
    logic [IDX_W-1:0]  cmd_idx = '0;
    logic [47:0]       cmd_va = '0;
    logic [5:0]        cmd_ps = 6'd12, shared_ps = 6'd12;
    logic [15:0]       cmd_lo0 = '0, cmd_lo1 = '0;
    logic [9:0]        cur_asid = '0, inv_asid = '0;
    logic              busy, done, res_ne, sd_valid;
    logic [IDX_W-1:0]  res_idx, sd_idx;
    logic [5:0]        res_ps;
    logic [47:0]       res_ehi;
    logic [15:0]       res_lo0, res_lo1;
    logic [9:0]        res_asid;

    int checks = 0, fails = 0;

    tlb_maint dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_idx(cmd_idx), .cmd_ne(cmd_ne), .cmd_va(cmd_va), .cmd_ps(cmd_ps),
        .cmd_lo0(cmd_lo0), .cmd_lo1(cmd_lo1), .cur_asid(cur_asid),
        .shared_ps(shared_ps), .inv_asid(inv_asid), .inv_g(inv_g),
        .busy(busy), .done(done), .res_ne(res_ne), .res_idx(res_idx),
        .res_ps(res_ps), .res_ehi(res_ehi), .res_lo0(res_lo0), .res_lo1(res_lo1),
        .res_asid(res_asid), .sd_valid(sd_valid), .sd_idx(sd_idx));

    localparam logic [47:0] VA_A = {27'h123, 8'd5, 13'h0};
    localparam logic [47:0] VA_B = {26'h2AB, 22'h0};
    localparam logic [47:0] VA_C = {27'h55, 8'd9, 13'h0};
    localparam logic [47:0] VA_D = {33'h1ABCD, 15'h0};
    localparam logic [47:0] VA_E = {26'h111, 22'h0};

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run(input logic [3:0] op);
        @(negedge clk);
        cmd_op = op; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!done) @(negedge clk);
    endtask

    task automatic wr(input int idx, input logic [47:0] va, input logic [5:0] ps,
                      input logic [9:0] asid, input logic [15:0] lo0, input logic [15:0] lo1,
                      input logic ne);
        cmd_idx = IDX_W'(idx); cmd_va = va; cmd_ps = ps; cur_asid = asid;
        cmd_lo0 = lo0; cmd_lo1 = lo1; cmd_ne = ne;
        run(4'd2);
    endtask

    task automatic rd(input int idx);
        cmd_idx = IDX_W'(idx);
        run(4'd1);
    endtask

    task automatic srch(input logic [47:0] va, input logic [9:0] asid);
        cmd_va = va; cur_asid = asid;
        run(4'd0);
    endtask

    task automatic t_reset();
        chk("R1 reset busy", 64'(busy), 0);
        chk("R1 reset done", 64'(done), 0);
        chk("R1 reset res_ne", 64'(res_ne), 0);
        chk("R13 reset sd_valid", 64'(sd_valid), 0);
    endtask

    task automatic t_write_read();
        wr(3*256+5, VA_A, 6'd12, 10'h011, 16'h0011, 16'h0022, 1'b0);
        chk("R13 write to empty entry no shootdown", 64'(sd_valid), 0);
        chk("R1 busy low at done", 64'(busy), 0);
        rd(3*256+5);
        chk("R4 read ne", 64'(res_ne), 0);
        chk("R4 read shared ps", 64'(res_ps), 12);
        chk("R3 read ehi", 64'(res_ehi), 64'(VA_A));
        chk("R3 read lo0", 64'(res_lo0), 16'h0011);
        chk("R3 read lo1", 64'(res_lo1), 16'h0022);
        chk("R3 read asid", 64'(res_asid), 10'h011);
    endtask

    task automatic t_search();
        srch(VA_A + 48'h1FFF, 10'h011);
        chk("R5 search hit ne", 64'(res_ne), 0);
        chk("R5 search hit idx", 64'(res_idx), 3*256+5);
        srch(VA_A, 10'h022);
        chk("R5 asid mismatch miss", 64'(res_ne), 1);
        chk("R5 miss keeps idx", 64'(res_idx), 3*256+5);
    endtask

    task automatic t_rewrite();
        wr(3*256+5, VA_A, 6'd12, 10'h011, 16'h0011, 16'h0022, 1'b0);
        chk("R13 overwrite shootdown", 64'(sd_valid), 1);
        chk("R13 shootdown idx", 64'(sd_idx), 3*256+5);
        wr(3*256+5, VA_A, 6'd12, 10'h011, 16'h0, 16'h0, 1'b1);
        chk("R13 ne write shootdown", 64'(sd_valid), 1);
        rd(3*256+5);
        chk("R3 ne write clears", 64'(res_ne), 1);
        chk("R4 absent zero lo0", 64'(res_lo0), 0);
        chk("R4 absent zero ehi", 64'(res_ehi), 0);
        chk("R4 absent zero asid", 64'(res_asid), 0);
        chk("R4 absent zero ps", 64'(res_ps), 0);
        wr(3*256+5, VA_A, 6'd12, 10'h099, 16'h0011, 16'h0, 1'b0);
        wr(3*256+5, VA_A, 6'd12, 10'h011, 16'h0011, 16'h0, 1'b0);
        chk("R13 other asid no shootdown", 64'(sd_valid), 0);
    endtask

    task automatic t_fa();
        wr(2050, VA_B, 6'd21, 10'h033, 16'h0041, 16'h0055, 1'b0);
        rd(2050);
        chk("R2 fa read own ps", 64'(res_ps), 21);
        chk("R2 fa read lo1", 64'(res_lo1), 16'h0055);
        srch(VA_B + 48'h3FFFFF, 10'h099);
        chk("R6 global in-page hit", 64'(res_ne), 0);
        chk("R6 hit idx", 64'(res_idx), 2050);
        srch(VA_B + 48'h400000, 10'h099);
        chk("R6 next pair misses", 64'(res_ne), 1);
    endtask

    task automatic t_fill();
        cmd_va = VA_C; cmd_ps = 6'd12; cur_asid = 10'h044; cmd_lo0 = 16'h0001; cmd_lo1 = 16'h0;
        run(4'd3);
        srch(VA_C, 10'h044);
        chk("R7 sa fill found", 64'(res_ne), 0);
        chk("R7 sa fill set", 64'(res_idx % 256), 9);
        chk("R7 sa fill part", 64'(res_idx < 2048), 1);
        cmd_va = VA_D; cmd_ps = 6'd14; cur_asid = 10'h044;
        run(4'd3);
        srch(VA_D + 48'h7FFF, 10'h044);
        chk("R7 fa fill found", 64'(res_ne), 0);
        chk("R7 fa fill part", 64'(res_idx >= 2048), 1);
    endtask

    task automatic t_clear_flush();
        wr(1*256+20, VA_C, 6'd12, 10'h055, 16'h0, 16'h0, 1'b0);
        wr(2*256+20, VA_C, 6'd12, 10'h066, 16'h0, 16'h0, 1'b0);
        wr(4*256+20, VA_C, 6'd12, 10'h055, 16'h0040, 16'h0, 1'b0);
        cmd_idx = 12'd20; cur_asid = 10'h055;
        run(4'd4);
        rd(1*256+20); chk("R8 clear matching", 64'(res_ne), 1);
        rd(2*256+20); chk("R8 other asid kept", 64'(res_ne), 0);
        rd(4*256+20); chk("R8 global kept", 64'(res_ne), 0);
        cmd_idx = 12'd20;
        run(4'd5);
        rd(2*256+20); chk("R9 flush other asid", 64'(res_ne), 1);
        rd(4*256+20); chk("R9 flush global", 64'(res_ne), 1);
        wr(2048, VA_E, 6'd21, 10'h055, 16'h0, 16'h0, 1'b0);
        wr(2049, VA_E, 6'd21, 10'h066, 16'h0, 16'h0, 1'b0);
        cmd_idx = 12'd2051; cur_asid = 10'h055;
        run(4'd4);
        rd(2048); chk("R8 fa clear matching", 64'(res_ne), 1);
        rd(2049); chk("R8 fa other asid kept", 64'(res_ne), 0);
    endtask

    task automatic t_inval();
        wr(2048, VA_E, 6'd21, 10'h005, 16'h0040, 16'h0, 1'b0);
        wr(2049, VA_E, 6'd21, 10'h005, 16'h0, 16'h0, 1'b0);
        wr(2051, VA_E, 6'd21, 10'h006, 16'h0, 16'h0, 1'b0);
        inv_g = 1'b1; run(4'd7);
        rd(2048); chk("R10 inv g=1 clears global", 64'(res_ne), 1);
        rd(2049); chk("R10 inv g=1 keeps local", 64'(res_ne), 0);
        inv_asid = 10'h005; run(4'd8);
        rd(2049); chk("R11 inv asid clears", 64'(res_ne), 1);
        rd(2051); chk("R11 inv asid keeps other", 64'(res_ne), 0);
        inv_asid = 10'h006; cmd_va = VA_B; run(4'd9);
        rd(2051); chk("R12 page miss keeps", 64'(res_ne), 0);
        cmd_va = VA_E + 48'h12345; run(4'd9);
        rd(2051); chk("R12 page asid clears", 64'(res_ne), 1);
        wr(2052, VA_E, 6'd21, 10'h007, 16'h0040, 16'h0, 1'b0);
        inv_asid = 10'h009; cmd_va = VA_E; run(4'd10);
        rd(2052); chk("R12 page or global clears", 64'(res_ne), 1);
        wr(2053, VA_E, 6'd21, 10'h007, 16'h0, 16'h0, 1'b0);
        run(4'd6);
        rd(2053); chk("R10 inv all clears", 64'(res_ne), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_read();
        t_search();
        t_rewrite();
        t_fa();
        t_fill();
        t_clear_flush();
        t_inval();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule